// File: doc/BRIEF.md
# Coded Sensor Clock Divider

This block derives the master clock sent to an image sensor from a fixed reference clock. A 5-bit code selects what the output does. It can hold the output low or high with the divider stopped. It can divide the reference by an integer between 2 and 30. It can also pass the reference through unchanged. Only the codes in the middle of the range divide. The bottom two codes and the all-ones code are reserved for the two steady levels and the pass-through.

The code may change at any time. The block applies a new code only when the current output period has run to completion, so software can reprogram the divider while the sensor is running. Entry into and exit from the pass-through path is timed to the low phase of the reference, which keeps the output free of runt pulses.

Top module: `sclk_div`

## Requirements
- R1: While reset is asserted the output is low. After reset the active code is the steady-low code 0 and the phase counter is zero, so a divide code present at release starts a full period on the first reference rising edge.
- R2: With code 0 active, the output stays low on every reference cycle.
- R3: With code 1 active, the output stays high on every reference cycle.
- R4: With a code N from 2 to 30 active, the output has exactly one rising edge every N reference cycles.
- R5: With a code N from 2 to 30 active, the output is high for floor(N/2) reference cycles of each period and low for the remaining N - floor(N/2). This gives a 50% duty cycle for even N.
- R6: With code 31 active, the output follows the reference clock: high in the reference high phase and low in its low phase.
- R7: While a divide code is active, a change of the code input has no effect until the last reference cycle of the current period has ended. The new code then starts its own period at phase zero. No output pulse is shorter than half a reference period.
- R8: The pass-through select changes only on a falling reference edge. The output therefore never shows a reference high phase cut short when it enters or leaves code 31.
- R9: While a steady or pass-through code is active, every reference rising edge ends a period. A new code takes effect at the first rising edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_i | input | 5 | Divider code: 0 low, 1 high, 2..30 divide, 31 pass-through |
| clk_o | output | 1 | Generated sensor clock |

## Verification
Several behaviours are checked on every cycle:
- the output is low in reset;
- the output stays at the steady level while code 0 or 1 is active;
- the output follows the reference while pass-through is active;
- each high phase of a divided period lasts exactly half the divisor, rounded down.

The frequency of each divisor, the length of the low phase, and the deferral of a code change to the period boundary are shown only by the bench scenarios. So are the shape of the output around entry to and exit from pass-through and the absence of pulses shorter than half a reference period. A behavioural model compares the output in the middle of every reference half-cycle, and a timing monitor measures every output pulse.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;

  typedef enum logic [1:0] {
    MODE_LOW  = 2'd0,
    MODE_HIGH = 2'd1,
    MODE_DIV  = 2'd2,
    MODE_BYP  = 2'd3
  } sclk_mode_e;

  // all-ones code is pass-through, 0 and 1 are steady levels
  function automatic sclk_mode_e decode_mode(input int unsigned code, input int unsigned code_w);
    int unsigned top_code;
    top_code = (32'd1 << code_w) - 32'd1;
    if (code == 0)             return MODE_LOW;
    else if (code == 1)        return MODE_HIGH;
    else if (code == top_code) return MODE_BYP;
    else                       return MODE_DIV;
  endfunction

  // output level in the first reference cycle of a period
  function automatic logic first_level(input sclk_mode_e m);
    return (m == MODE_HIGH) || (m == MODE_DIV);
  endfunction

endpackage

// File: rtl/sclk_div_phase.sv
module sclk_div_phase
  import sclk_div_pkg::*;
#(
  parameter int unsigned CODE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] act_i,
  input  logic [CODE_W-1:0] next_i,
  output logic              wrap_o,
  output logic              div_o
);

  logic [CODE_W-1:0] cnt_q, cnt_d, cnt_inc, half;
  logic              div_q, div_d;
  sclk_mode_e        act_mode, next_mode;

  assign act_mode  = decode_mode(32'(act_i), CODE_W);
  assign next_mode = decode_mode(32'(next_i), CODE_W);
  assign half      = act_i >> 1;
  assign cnt_inc   = cnt_q + 1'b1;

  // steady and pass-through codes end a period on every edge
  assign wrap_o = (act_mode != MODE_DIV) || (cnt_q == act_i - 1'b1);

  always_comb begin
    if (wrap_o) begin
      cnt_d = '0;
      div_d = first_level(next_mode);
    end else begin
      cnt_d = cnt_inc;
      div_d = cnt_inc < half;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      div_q <= div_d;
    end
  end

  assign div_o = div_q;

endmodule

// File: rtl/sclk_div_latch.sv
module sclk_div_latch #(
  parameter int unsigned CODE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wrap_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] act_o
);

  logic [CODE_W-1:0] act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     act_q <= '0;
    else if (wrap_i) act_q <= code_i;
  end

  assign act_o = act_q;

endmodule

// File: rtl/sclk_div_outsel.sv
module sclk_div_outsel
  import sclk_div_pkg::*;
#(
  parameter int unsigned CODE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] act_i,
  input  logic              div_i,
  output logic              byp_o,
  output logic              clk_o
);

  logic byp_q;

  // select moves while the reference is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) byp_q <= 1'b0;
    else         byp_q <= (decode_mode(32'(act_i), CODE_W) == MODE_BYP);
  end

  assign byp_o = byp_q;
  assign clk_o = byp_q ? clk_i : div_i;

endmodule

// File: rtl/sclk_div.sv
module sclk_div #(
  parameter int unsigned CODE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  output logic              clk_o
);

  logic [CODE_W-1:0] act_q;
  logic              wrap;
  logic              div_q;
  logic              byp_q;

  sclk_div_latch #(.CODE_W(CODE_W)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wrap_i (wrap),
    .code_i (code_i),
    .act_o  (act_q)
  );

  sclk_div_phase #(.CODE_W(CODE_W)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (act_q),
    .next_i (code_i),
    .wrap_o (wrap),
    .div_o  (div_q)
  );

  sclk_div_outsel #(.CODE_W(CODE_W)) u_outsel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (act_q),
    .div_i  (div_q),
    .byp_o  (byp_q),
    .clk_o  (clk_o)
  );

endmodule

// File: rtl/sclk_div_chk.sv
module sclk_div_chk #(
  parameter int unsigned CODE_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CODE_W-1:0] act_i,
  input logic              div_i,
  input logic              clk_o_i
);

  localparam logic [CODE_W-1:0] BYP_CODE = '1;
  localparam logic [CODE_W-1:0] RUN_MAX  = '1;

  logic [CODE_W-1:0] run_q;
  logic              from_hi_q;
  logic              act_div;

  assign act_div = (act_i >= CODE_W'(2)) && (act_i != BYP_CODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= '0;
      from_hi_q <= 1'b0;
    end else begin
      if (!div_i)              run_q <= '0;
      else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
      if (!div_i)              from_hi_q <= 1'b0;
      else if (act_i == CODE_W'(1)) from_hi_q <= 1'b1;
    end
  end

  // R1
  reset_low_chk: assert property (@(posedge clk_i) !rst_ni |-> !clk_o_i);

  // R2
  steady_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == '0 && $past(act_i) == '0) |-> !clk_o_i);

  // R3
  steady_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == CODE_W'(1) && $past(act_i) == CODE_W'(1)) |-> clk_o_i);

  // R5
  high_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(div_i) && act_div && !from_hi_q) |-> run_q == (act_i >> 1));

  // R6
  bypass_follow_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (act_i == BYP_CODE && $past(act_i) == BYP_CODE) |-> clk_o_i);

endmodule

bind sclk_div sclk_div_chk #(.CODE_W(CODE_W)) u_sclk_div_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .act_i   (act_q),
  .div_i   (div_q),
  .clk_o_i (clk_o)
);

// File: tb/sclk_div_bench.sv
`timescale 1ns/1ps
module sclk_div_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] code = 5'd5;
  logic       clk_o;

  int    n_run = 0;
  int    n_fail = 0;
  string cur_req = "R1";
  bit    done = 0;

  sclk_div u_sclk_div (.clk_i(clk), .rst_ni(rst_n), .code_i(code), .clk_o(clk_o));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_act = 0, m_pos = 0, m_div = 0, m_byp = 0;

  function automatic int m_len(int c);
    return (c >= 2 && c <= 30) ? c : 1;
  endfunction

  function automatic int m_lvl(int c, int p);
    if (c == 1) return 1;
    if (c >= 2 && c <= 30) return (p < c / 2) ? 1 : 0;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_pos = 0; m_div = 0;
    end else begin
      if (m_pos == m_len(m_act) - 1) begin
        m_act = int'(code); m_pos = 0;
      end else m_pos++;
      m_div = m_lvl(m_act, m_pos);
    end
  end

  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) m_byp = 0;
    else        m_byp = (m_act == 31) ? 1 : 0;
  end

  always @(posedge clk) begin
    #5;
    if (!done) chk(int'(clk_o) == (m_byp ? 1 : m_div), cur_req, int'(clk_o), m_byp ? 1 : m_div);
  end

  always @(negedge clk) begin
    #5;
    if (!done) chk(int'(clk_o) == (m_byp ? 0 : m_div), cur_req, int'(clk_o), m_byp ? 0 : m_div);
  end

  // pulse width monitor, R7/R8: no pulse shorter than half a reference period
  realtime last_t = 0.0;
  int      runts = 0;
  always @(clk_o) begin
    if (rst_n && !done) begin
      if (($realtime - last_t) > 0.0 && ($realtime - last_t) < 9.5) runts++;
    end
    last_t = $realtime;
  end

  task automatic set_code(input int c);
    @(negedge clk); #2;
    code = 5'(c);
  endtask

  task automatic check_div(input int n);
    int rises = 0, highs = 0, prev;
    cur_req = "R5";
    set_code(n);
    repeat (64) @(posedge clk);
    #5; prev = int'(clk_o);
    for (int k = 0; k < 4 * n; k++) begin
      @(posedge clk); #5;
      if (clk_o) highs++;
      if (clk_o && prev == 0) rises++;
      prev = int'(clk_o);
    end
    chk(rises == 4, "R4", rises, 4);
    chk(highs == 4 * (n / 2), "R5", highs, 4 * (n / 2));
  endtask

  initial begin
    #1;
    chk(clk_o == 1'b0, "R1", int'(clk_o), 0);
    repeat (3) @(posedge clk);
    #5 chk(clk_o == 1'b0, "R1", int'(clk_o), 0);
    @(negedge clk); #2 rst_n = 1'b1;
    // code 5 at release: high 2 cycles, low 3
    for (int k = 0; k < 5; k++) begin
      @(posedge clk); #5;
      chk(int'(clk_o) == (k < 2 ? 1 : 0), "R1", int'(clk_o), k < 2 ? 1 : 0);
    end

    check_div(2);
    check_div(3);
    check_div(4);
    check_div(7);
    check_div(16);
    check_div(30);

    cur_req = "R2";
    set_code(0);
    repeat (40) @(posedge clk);
    for (int k = 0; k < 10; k++) begin
      @(posedge clk); #5 chk(clk_o == 1'b0, "R2", int'(clk_o), 0);
    end

    cur_req = "R9";
    set_code(1);
    @(posedge clk); #5 chk(clk_o == 1'b1, "R9", int'(clk_o), 1);
    cur_req = "R3";
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); #5 chk(clk_o == 1'b1, "R3", int'(clk_o), 1);
    end

    cur_req = "R6";
    set_code(31);
    repeat (3) @(posedge clk);
    for (int k = 0; k < 8; k++) begin
      @(posedge clk); #5 chk(clk_o == 1'b1, "R6", int'(clk_o), 1);
      @(negedge clk); #5 chk(clk_o == 1'b0, "R6", int'(clk_o), 0);
    end

    cur_req = "R8";
    set_code(4);  repeat (12) @(posedge clk);
    set_code(31); repeat (6) @(posedge clk);
    set_code(0);  repeat (6) @(posedge clk);
    set_code(31); repeat (6) @(posedge clk);
    set_code(1);  repeat (6) @(posedge clk);
    set_code(3);  repeat (12) @(posedge clk);

    // R7: change mid-period is deferred to the period end
    cur_req = "R7";
    set_code(9);
    repeat (40) @(posedge clk);
    begin
      int prev;
      #5 prev = int'(clk_o);
      forever begin
        @(posedge clk); #5;
        if (clk_o && prev == 0) break;
        prev = int'(clk_o);
      end
    end
    @(negedge clk); #2 code = 5'd2;
    for (int k = 1; k < 9; k++) begin
      @(posedge clk); #5 chk(int'(clk_o) == (k < 4 ? 1 : 0), "R7", int'(clk_o), k < 4 ? 1 : 0);
    end
    @(posedge clk); #5 chk(clk_o == 1'b1, "R7", int'(clk_o), 1);
    @(posedge clk); #5 chk(clk_o == 1'b0, "R7", int'(clk_o), 0);
    repeat (4) @(posedge clk);

    #1 chk(runts == 0, "R8", runts, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    done = 1;
    n_run++; n_fail++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule